// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block moves data words from a write clock domain to an unrelated read clock domain. The FIFO runs in fall-through mode: once a word has crossed into the read domain, it is loaded into the output register and driven on the read data bus without any read request. A read enable pulse consumes the presented word. The next stored word, if there is one, replaces it on the same read-clock edge.

The output register is one storage slot in its own right. A memory of 2^AW words therefore gives a total capacity of D = 2^AW + 1 words.

Status is reported through five flags. In the read domain there is an active-low output-ready flag and an almost-empty flag. In the write domain there is an active-low input-ready flag (high means full), an almost-full flag and a half-full flag. The almost-empty offset n and the almost-full offset m are elaboration parameters.

Pointers cross between the domains as Gray code through two-flop synchronizers. The read side publishes two pointers:
- a fetch pointer, which counts words moved from memory into the output register;
- a consume pointer, which counts words actually taken by the reader.

Top module: `fwft_fifo`

## Requirements
- R1: With no reads, input-ready `ir_n` is low while fewer than D words are stored. It goes high on the write-clock edge that stores word D (D = 17 for the defaults AW=4), provided the first word has already been loaded into the output register.
- R2: After a write into an empty FIFO, `or_n` is still high after the first and second rising read-clock edges that follow the write edge. It is low after the third.
- R3: When `or_n` falls, `rdata` already carries the first word written, and no read enable is needed.
- R4: While `ren` is low, `rdata` and `or_n` keep their values.
- R5: `pae_n` is high when at least n+1 words are stored and low when n or fewer are stored (n = AE_OFS = 3). It is updated in the read domain, on the third read-clock edge after the write edge.
- R6: `paf_n` goes low on the write-clock edge that brings the stored count to D-m+1 or more (m = AF_OFS = 3, so 15). It returns high once reads bring the count below that threshold.
- R7: `hf_n` goes low on the write-clock edge that brings the stored count to (D-1)/2+1 or more (9 for the defaults). It is high below that count.
- R8: While reset is applied and after it is released, `or_n`=1, `pae_n`=0, `ir_n`=0, `paf_n`=1 and `hf_n`=1.
- R9: A read enable given while `or_n` is high is ignored. No word is lost and the consume pointer does not move.
- R10: Words leave the FIFO in the order they were written.
- R11: Each Gray-coded pointer published across domains changes by at most one bit per clock of its domain.
- R12: A write issued while `ir_n` is high does not store a word, and the write pointer stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wen | input | 1 | Write enable |
| wdata | input | DW | Write data |
| ir_n | output | 1 | Input-ready, active low (high = full) |
| paf_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| ren | input | 1 | Read enable (consumes presented word) |
| rdata | output | DW | Read data from output register |
| or_n | output | 1 | Output-ready, active low (low = word valid) |
| pae_n | output | 1 | Almost-empty, active low |

## Verification
The write-domain flags change on the same write-clock edge that accepts the word, so the bench samples them half a nanosecond after that edge. A written word needs one edge for each of the two synchronizer stages plus one register load before it reaches the read side. The bench therefore counts read-clock edges after each write and samples `or_n`, `rdata` and `pae_n` half a nanosecond after the second and the third of those edges. Clock edges of the two domains never coincide (write edges at even nanoseconds, read edges at odd ones), which keeps these edge counts exact.

// File: rtl/fwft_fifo_pkg.sv
`timescale 1ns/1ps
package fwft_fifo_pkg;

    typedef struct packed {
        logic ir_n;
        logic paf_n;
        logic hf_n;
    } wr_flags_t;

    typedef struct packed {
        logic or_n;
        logic pae_n;
    } rd_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fwft_sync.sv
`timescale 1ns/1ps
module fwft_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fwft_ram.sv
`timescale 1ns/1ps
module fwft_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] store [WORDS];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fwft_wr_ctl.sv
`timescale 1ns/1ps
module fwft_wr_ctl
    import fwft_fifo_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AF_OFS = 3
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [AW:0]   cons_gray_s,
    input  logic [AW:0]   fetch_gray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output wr_flags_t     flags
);
    localparam int CW    = AW + 1;
    localparam int DEPTH = (2 ** AW) + 1;
    localparam logic [CW-1:0] MEM_WORDS = CW'(2 ** AW);
    localparam logic [CW-1:0] AF_TH     = CW'(DEPTH - AF_OFS + 1);
    localparam logic [CW-1:0] HF_TH     = CW'((DEPTH - 1) / 2 + 1);

    logic [CW-1:0] wbin, wbin_nx, cons_bin, fetch_bin, cnt_nx;

    assign cons_bin  = CW'(gray2bin(32'(cons_gray_s)));
    assign fetch_bin = CW'(gray2bin(32'(fetch_gray_s)));

    // Registered full flag gates writes; it is conservative because the
    // synchronized fetch pointer can only lag the real one.
    assign we      = wen && !flags.ir_n;
    assign wbin_nx = wbin + CW'(we);
    assign cnt_nx  = wbin_nx - cons_bin;
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin        <= '0;
            wgray       <= '0;
            flags.ir_n  <= 1'b0;
            flags.paf_n <= 1'b1;
            flags.hf_n  <= 1'b1;
        end else begin
            wbin        <= wbin_nx;
            wgray       <= CW'(bin2gray(32'(wbin_nx)));
            flags.ir_n  <= ((wbin_nx - fetch_bin) == MEM_WORDS);
            flags.paf_n <= !(cnt_nx >= AF_TH);
            flags.hf_n  <= !(cnt_nx >= HF_TH);
        end
    end
endmodule

// File: rtl/fwft_rd_ctl.sv
`timescale 1ns/1ps
module fwft_rd_ctl
    import fwft_fifo_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AE_OFS = 3
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          ren,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   fetch_gray,
    output logic [AW:0]   cons_gray,
    output logic [DW-1:0] rdata,
    output rd_flags_t     flags
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] AE_TH = CW'(AE_OFS + 1);

    logic [CW-1:0] fbin, fbin_nx, cbin_nx, wbin_s, cnt_nx;
    logic          held, held_nx, avail, consume, fetch;

    assign wbin_s  = CW'(gray2bin(32'(wgray_s)));
    assign avail   = (wbin_s != fbin);
    assign consume = ren && held;
    assign fetch   = avail && (!held || consume);
    assign fbin_nx = fbin + CW'(fetch);
    assign held_nx = fetch || (held && !consume);
    assign cbin_nx = fbin_nx - CW'(held_nx);
    assign cnt_nx  = wbin_s - cbin_nx;
    assign raddr   = fbin[AW-1:0];
    assign flags.or_n = !held;

    always_ff @(posedge rclk) begin
        if (rrst) begin
            fbin        <= '0;
            held        <= 1'b0;
            fetch_gray  <= '0;
            cons_gray   <= '0;
            rdata       <= '0;
            flags.pae_n <= 1'b0;
        end else begin
            fbin        <= fbin_nx;
            held        <= held_nx;
            fetch_gray  <= CW'(bin2gray(32'(fbin_nx)));
            cons_gray   <= CW'(bin2gray(32'(cbin_nx)));
            if (fetch) rdata <= mem_q;
            flags.pae_n <= (cnt_nx >= AE_TH);
        end
    end
endmodule

// File: rtl/fwft_fifo.sv
`timescale 1ns/1ps
module fwft_fifo
    import fwft_fifo_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AE_OFS = 3,
    parameter int AF_OFS = 3
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic          ir_n,
    output logic          paf_n,
    output logic          hf_n,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    output logic          or_n,
    output logic          pae_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, wgray_s, fgray, fgray_s, cgray, cgray_s;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_q;
    logic          we;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    fwft_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_q)
    );

    fwft_wr_ctl #(.AW(AW), .AF_OFS(AF_OFS)) u_wr (
        .wclk(wclk), .wrst(wrst), .wen(wen),
        .cons_gray_s(cgray_s), .fetch_gray_s(fgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .flags(wflags)
    );

    fwft_rd_ctl #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS)) u_rd (
        .rclk(rclk), .rrst(rrst), .ren(ren), .wgray_s(wgray_s),
        .mem_q(mem_q), .raddr(raddr), .fetch_gray(fgray),
        .cons_gray(cgray), .rdata(rdata), .flags(rflags)
    );

    fwft_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
    fwft_sync #(.W(PW)) u_f2w (.clk(wclk), .rst(wrst), .d(fgray), .q(fgray_s));
    fwft_sync #(.W(PW)) u_c2w (.clk(wclk), .rst(wrst), .d(cgray), .q(cgray_s));

    assign ir_n  = wflags.ir_n;
    assign paf_n = wflags.paf_n;
    assign hf_n  = wflags.hf_n;
    assign or_n  = rflags.or_n;
    assign pae_n = rflags.pae_n;
endmodule

// File: rtl/fwft_fifo_chk.sv
`timescale 1ns/1ps
module fwft_fifo_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          wclk,
    input logic          wrst,
    input logic          wen,
    input logic          ir_n,
    input logic          paf_n,
    input logic          rclk,
    input logic          rrst,
    input logic          ren,
    input logic [DW-1:0] rdata,
    input logic          or_n,
    input logic          pae_n,
    input logic [AW:0]   wgray,
    input logic [AW:0]   cgray,
    input logic [AW:0]   fgray
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (wrst)
        (ir_n && wen) |=> $stable(wgray)); // R12

    AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1); // R11

    AST_CGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rrst)
        $countones(cgray ^ $past(cgray)) <= 1); // R11

    AST_FGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (rrst)
        $countones(fgray ^ $past(fgray)) <= 1); // R11

    AST_HOLD_OUTPUT: assert property (@(posedge rclk) disable iff (rrst)
        (!or_n && !ren) |=> ($stable(rdata) && !or_n)); // R4

    AST_IGNORED_READ: assert property (@(posedge rclk) disable iff (rrst)
        (or_n && ren) |=> $stable(cgray)); // R9

    AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (wrst)
        ir_n |-> !paf_n); // R6

    AST_RESET_EMPTY: assert property (@(posedge rclk)
        rrst |=> (or_n && !pae_n)); // R8
endmodule

bind fwft_fifo fwft_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk(wclk), .wrst(wrst), .wen(wen), .ir_n(ir_n), .paf_n(paf_n),
    .rclk(rclk), .rrst(rrst), .ren(ren), .rdata(rdata), .or_n(or_n),
    .pae_n(pae_n), .wgray(wgray), .cgray(cgray), .fgray(fgray)
);

// File: tb/fwft_fifo_test.sv
`timescale 1ns/1ps
module fwft_fifo_test;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wrst = 1'b1, rrst = 1'b1;
    logic       wen = 1'b0, ren = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ir_n, paf_n, hf_n, or_n, pae_n;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    fwft_fifo uut (
        .wclk(wclk), .wrst(wrst), .wen(wen), .wdata(wdata),
        .ir_n(ir_n), .paf_n(paf_n), .hf_n(hf_n),
        .rclk(rclk), .rrst(rrst), .ren(ren), .rdata(rdata),
        .or_n(or_n), .pae_n(pae_n)
    );

    // 250 MHz write clock: rising edges at 2,6,10,... ns
    always #2 wclk = ~wclk;
    // read clock: rising edges at 3,9,15,... ns, never on a write edge
    always #3 rclk = ~rclk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge wclk);
        wen   = 1'b1;
        wdata = v;
        @(posedge wclk);
        #0.5;
        wen = 1'b0;
    endtask

    task automatic pop(output logic [7:0] v);
        @(posedge rclk);
        #0.5;
        v   = rdata;
        ren = 1'b1;
        @(posedge rclk);
        #0.5;
        ren = 1'b0;
    endtask

    task automatic rwait(input int n);
        repeat (n) @(posedge rclk);
        #0.5;
    endtask

    task automatic t_reset;
        repeat (4) @(posedge rclk);
        #0.5;
        check("R8 or_n", or_n, 1);
        check("R8 pae_n", pae_n, 0);
        check("R8 ir_n", ir_n, 0);
        check("R8 paf_n", paf_n, 1);
        check("R8 hf_n", hf_n, 1);
        @(negedge wclk);
        wrst = 1'b0;
        @(negedge rclk);
        rrst = 1'b0;
        rwait(3);
        check("R8 or_n after release", or_n, 1);
        check("R8 ir_n after release", ir_n, 0);
    endtask

    task automatic t_fall_through;
        logic [7:0] v;
        push(8'hA5);
        rwait(1);
        check("R2 or_n edge1", or_n, 1);
        rwait(1);
        check("R2 or_n edge2", or_n, 1);
        rwait(1);
        check("R2 or_n edge3", or_n, 0);
        check("R3 first word", rdata, 8'hA5);
        rwait(6);
        check("R4 hold or_n", or_n, 0);
        check("R4 hold rdata", rdata, 8'hA5);
        pop(v);
        check("R10 popped", v, 8'hA5);
        rwait(2);
        check("R9 empty after pop", or_n, 1);
    endtask

    task automatic t_ignored_read;
        logic [7:0] v;
        @(posedge rclk);
        #0.5;
        ren = 1'b1;
        rwait(4);
        ren = 1'b0;
        check("R9 or_n after idle read", or_n, 1);
        push(8'h3C);
        rwait(3);
        check("R9 word after idle read", rdata, 8'h3C);
        check("R9 or_n", or_n, 0);
        pop(v);
        rwait(2);
        check("R9 empty again", or_n, 1);
    endtask

    task automatic t_fill_drain;
        logic [7:0] v;
        int         got;
        for (int k = 1; k <= 17; k++) begin
            push(8'h40 + 8'(k));
            check("R7 hf_n", hf_n, (k >= 9) ? 0 : 1);
            check("R6 paf_n", paf_n, (k >= 15) ? 0 : 1);
            check("R1 ir_n", ir_n, (k >= 17) ? 1 : 0);
            if (k == 3) begin
                rwait(5);
                check("R5 pae_n at n", pae_n, 0);
            end
            if (k == 4) begin
                rwait(5);
                check("R5 pae_n at n+1", pae_n, 1);
            end
        end
        push(8'hEE);
        check("R12 ir_n stays", ir_n, 1);
        check("R12 hf_n stays", hf_n, 0);
        got = 0;
        for (int i = 1; i <= 17; i++) begin
            pop(v);
            check("R10 order", v, 8'h40 + 8'(i));
            got++;
        end
        rwait(4);
        check("R12 no extra word", or_n, 1);
        check("R5 pae_n empty", pae_n, 0);
        repeat (6) @(posedge wclk);
        #0.5;
        check("R1 ir_n released", ir_n, 0);
        check("R6 paf_n released", paf_n, 1);
        check("R7 hf_n released", hf_n, 1);
        check("R10 count", got, 17);
    endtask

    initial begin
        t_reset();
        t_fall_through();
        t_ignored_read();
        t_fill_drain();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge wclk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule